// File: doc/BRIEF.md
# Depth-Expansion FIFO Slice Chain

This block builds one deep first-in/first-out buffer out of several identical storage slices connected in a ring. Every slice has its own memory, its own pointers and its own word count. The write strobe, the read strobe, the write data and the reset go to all slices at once. Only one slice acts on writes at a time: the one holding the write token. Only one slice acts on reads at a time: the one holding the read token.

A slice that writes its highest location hands the write token to the next slice in the ring. It does this with a one-cycle pulse on its expansion output. Reading its highest location hands the read token on in the same way, with a separate pulse. A slice tells the two kinds of incoming pulse apart by tracking which token it expects next, because the two kinds alternate. The wrapper picks the head slice, which holds both tokens after reset. It also merges the per-slice flags and read data into one buffer interface.

With a single slice the block falls back to single-device operation. That slice keeps both tokens forever and never pulses its expansion output.

Top module: `fifo_chain`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `empty_n` is low, `full_n` is high and `rd_valid` is low. The first word written after reset is the first word read, whatever was stored before.
- R2: Words leave in the order they were written, across all slice boundaries and across any number of trips around the ring.
- R3: `full_n` is low exactly when the chain holds SLICES*DEPTH words.
- R4: A write strobe while `full_n` is low is dropped. That word is never read out, and the stored words are unchanged.
- R5: A read strobe while `empty_n` is low has no effect. `rd_valid` stays low in the following cycle and the stored words are unchanged.
- R6: An accepted read raises `rd_valid` for exactly the next cycle, with the oldest word on `rd_data`. Without an accepted read, `rd_valid` is low in the next cycle.
- R7: At every cycle after reset, exactly one slice holds the write token and exactly one holds the read token. At reset the slice chosen by HEAD takes both tokens.
- R8: A token moves only after an expansion pulse. A pulse is issued in the cycle a slice writes (or reads) its location DEPTH-1. The next slice in the ring then takes the token and continues at its location 0.
- R9: `empty_n` goes low only when every slice is empty. `full_n` goes low only when every slice is full. A chain whose head slice is drained but whose next slice still holds words reports non-empty.
- R10: With SLICES=1, the block acts as a plain buffer of DEPTH words: it fills after DEPTH writes, drops further writes, and keeps the write order.
- R11: When the chain is neither empty nor full, a read and a write strobe in the same cycle are both accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, shared by all slices |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read strobe, shared by all slices |
| rd_data | output | WIDTH | Word read, valid while `rd_valid` is high |
| rd_valid | output | 1 | High the cycle after an accepted read |
| empty_n | output | 1 | Low when the whole chain is empty |
| full_n | output | 1 | Low when the whole chain is full |

## Verification
The hardest situation to reach from the ports is a slice that must sort out an incoming expansion pulse after its tokens have gone several times around the ring. By then the write and read tokens sit in different slices, and their pulses arrive interleaved.

The bench gets there with a long mixed sequence. It writes on two cycles out of three and reads on three cycles out of five, which pushes several times the total capacity through a three-slice chain whose head is not slice 0. It also holds the fill level near half so that reads and writes hit the same cycles. An independent queue model predicts each word and both flags after every edge.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

   // Which token a slice expects from its next expansion-in pulse.
   typedef enum logic {
      EXP_WR = 1'b0,
      EXP_RD = 1'b1
   } tok_expect_e;

   // Address width needed to index a slice of the given depth.
   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/chain_store.sv
module chain_store #(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = fifo_chain_pkg::addr_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      if (re) begin
         rdata <= mem[raddr];
      end
   end

endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
   import fifo_chain_pkg::*;
#(
   parameter int unsigned DEPTH   = 8,
   parameter bit          CHAINED = 1'b1,
   parameter int unsigned AW      = addr_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          head_n,
   input  logic          xi,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic          re,
   output logic [AW-1:0] raddr,
   output logic          empty,
   output logic          full,
   output logic          xo,
   output logic          wtok,
   output logic          rtok
);

   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0] wptr_q;
   logic [AW-1:0] rptr_q;
   logic [CW-1:0] cnt_q;
   logic          w_last;
   logic          r_last;

   assign empty  = (cnt_q == '0);
   assign full   = (cnt_q == CW'(DEPTH));
   assign we     = wr_en & wtok & ~full;
   assign re     = rd_en & rtok & ~empty;
   assign w_last = (wptr_q == LAST);
   assign r_last = (rptr_q == LAST);
   assign waddr  = wptr_q;
   assign raddr  = rptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (we) begin
            wptr_q <= w_last ? '0 : wptr_q + 1'b1;
         end
         if (re) begin
            rptr_q <= r_last ? '0 : rptr_q + 1'b1;
         end
         cnt_q <= cnt_q + CW'(we) - CW'(re);
      end
   end

   generate
      if (CHAINED) begin : g_ring
         logic        wtok_q;
         logic        rtok_q;
         tok_expect_e expect_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wtok_q   <= ~head_n;
               rtok_q   <= ~head_n;
               expect_q <= EXP_WR;
            end else begin
               if (we && w_last) begin
                  wtok_q <= 1'b0;
               end
               if (re && r_last) begin
                  rtok_q <= 1'b0;
               end
               if (xi) begin
                  if (expect_q == EXP_WR) begin
                     wtok_q   <= 1'b1;
                     expect_q <= EXP_RD;
                  end else begin
                     rtok_q   <= 1'b1;
                     expect_q <= EXP_WR;
                  end
               end
            end
         end

         assign wtok = wtok_q;
         assign rtok = rtok_q;
         assign xo   = (we & w_last) | (re & r_last);
      end else begin : g_solo
         logic tie_unused;
         assign tie_unused = xi ^ head_n;
         assign wtok = 1'b1;
         assign rtok = 1'b1;
         assign xo   = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/chain_slice.sv
module chain_slice
   import fifo_chain_pkg::*;
#(
   parameter int unsigned WIDTH   = 9,
   parameter int unsigned DEPTH   = 8,
   parameter bit          CHAINED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             head_n,
   input  logic             xi,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_valid,
   output logic             empty,
   output logic             full,
   output logic             xo,
   output logic             wtok,
   output logic             rtok
);

   localparam int unsigned AW = addr_bits(DEPTH);

   logic          we;
   logic          re;
   logic [AW-1:0] waddr;
   logic [AW-1:0] raddr;
   logic          valid_q;

   chain_ctrl #(
      .DEPTH   (DEPTH),
      .CHAINED (CHAINED),
      .AW      (AW)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .head_n (head_n),
      .xi     (xi),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .we     (we),
      .waddr  (waddr),
      .re     (re),
      .raddr  (raddr),
      .empty  (empty),
      .full   (full),
      .xo     (xo),
      .wtok   (wtok),
      .rtok   (rtok)
   );

   chain_store #(
      .WIDTH (WIDTH),
      .DEPTH (DEPTH),
      .AW    (AW)
   ) u_store (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wr_data),
      .re    (re),
      .raddr (raddr),
      .rdata (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else begin
         valid_q <= re;
      end
   end

   assign rd_valid = valid_q;

endmodule

// File: rtl/fifo_chain.sv
module fifo_chain #(
   parameter int unsigned WIDTH  = 9,
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned SLICES = 3,
   parameter int unsigned HEAD   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_valid,
   output logic             empty_n,
   output logic             full_n
);

   localparam bit CHAINED = (SLICES > 1);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("fifo_chain: WIDTH must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("fifo_chain: DEPTH must be at least 2");
      end
      if (SLICES < 1) begin : g_bad_slices
         $error("fifo_chain: SLICES must be at least 1");
      end
      if (HEAD >= SLICES) begin : g_bad_head
         $error("fifo_chain: HEAD must name an existing slice");
      end
   endgenerate

   logic [SLICES-1:0] slc_empty;
   logic [SLICES-1:0] slc_full;
   logic [SLICES-1:0] slc_xo;
   logic [SLICES-1:0] slc_wtok;
   logic [SLICES-1:0] slc_rtok;
   logic [SLICES-1:0] slc_valid;
   logic [WIDTH-1:0]  slc_data [SLICES];

   generate
      for (genvar i = 0; i < SLICES; i++) begin : g_slc
         localparam int unsigned PREV = (i == 0) ? SLICES - 1 : i - 1;

         chain_slice #(
            .WIDTH   (WIDTH),
            .DEPTH   (DEPTH),
            .CHAINED (CHAINED)
         ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .head_n   (i != HEAD),
            .xi       (slc_xo[PREV]),
            .wr_en    (wr_en),
            .wr_data  (wr_data),
            .rd_en    (rd_en),
            .rd_data  (slc_data[i]),
            .rd_valid (slc_valid[i]),
            .empty    (slc_empty[i]),
            .full     (slc_full[i]),
            .xo       (slc_xo[i]),
            .wtok     (slc_wtok[i]),
            .rtok     (slc_rtok[i])
         );
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < SLICES; k++) begin
         rd_data = rd_data | (slc_data[k] & {WIDTH{slc_valid[k]}});
      end
   end

   assign rd_valid = |slc_valid;
   assign empty_n  = |(~slc_empty);
   assign full_n   = |(~slc_full);

endmodule

// File: rtl/fifo_chain_chk.sv
module fifo_chain_chk #(
   parameter int unsigned SLICES = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic              rd_valid,
   input logic              empty_n,
   input logic              full_n,
   input logic [SLICES-1:0] wtok,
   input logic [SLICES-1:0] rtok,
   input logic [SLICES-1:0] xo
);

   AST_WTOK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wtok) == 1) else $error("write token not held by one slice"); // R7
   AST_RTOK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rtok) == 1) else $error("read token not held by one slice"); // R7
   AST_WTOK_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wtok) |-> $past(|xo)) else $error("write token moved without pulse"); // R8
   AST_RTOK_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rtok) |-> $past(|xo)) else $error("read token moved without pulse"); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n && wr_en && !rd_en |=> !full_n) else $error("full chain changed on write"); // R4
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !empty_n |=> !rd_valid) else $error("read from empty chain"); // R5
   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && empty_n |=> rd_valid) else $error("accepted read gave no valid"); // R6
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid) else $error("valid without read"); // R6
   AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> empty_n) else $error("full and empty together"); // R9

endmodule

bind fifo_chain fifo_chain_chk #(.SLICES(SLICES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .rd_valid (rd_valid),
   .empty_n  (empty_n),
   .full_n   (full_n),
   .wtok     (slc_wtok),
   .rtok     (slc_rtok),
   .xo       (slc_xo)
);

// File: tb/tb_fifo_chain.sv
`timescale 1ns/1ps
module tb_fifo_chain;

   localparam int W      = 9;
   localparam int DEPTH  = 4;
   localparam int SLICES = 3;
   localparam int CAP    = DEPTH * SLICES;
   localparam int SDEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic         c_wr = 1'b0, c_rd = 1'b0;
   logic [W-1:0] c_wd = '0;
   logic [W-1:0] c_rdata;
   logic         c_valid, c_empty_n, c_full_n;

   logic         s_wr = 1'b0, s_rd = 1'b0;
   logic [W-1:0] s_wd = '0;
   logic [W-1:0] s_rdata;
   logic         s_valid, s_empty_n, s_full_n;

   fifo_chain #(.WIDTH(W), .DEPTH(DEPTH), .SLICES(SLICES), .HEAD(1)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(c_wr), .wr_data(c_wd), .rd_en(c_rd),
      .rd_data(c_rdata), .rd_valid(c_valid), .empty_n(c_empty_n), .full_n(c_full_n)
   );

   fifo_chain #(.WIDTH(W), .DEPTH(SDEPTH), .SLICES(1), .HEAD(0)) dut_solo (
      .clk(clk), .rst_n(rst_n), .wr_en(s_wr), .wr_data(s_wd), .rd_en(s_rd),
      .rd_data(s_rdata), .rd_valid(s_valid), .empty_n(s_empty_n), .full_n(s_full_n)
   );

   int checks = 0;
   int fails  = 0;
   logic [W-1:0] seq = 9'd1;
   logic [W-1:0] cq[$];
   logic [W-1:0] sq[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // One clock of stimulus on one instance, then a full check against the model.
   task automatic step(input bit solo, input bit w, input bit r, input string tag);
      logic [W-1:0] d;
      logic [W-1:0] ed;
      bit aw, ar;
      int cap, sz;
      d   = seq;
      seq = seq + 9'd1;
      cap = solo ? SDEPTH : CAP;
      sz  = solo ? sq.size() : cq.size();
      aw  = w && (sz < cap);
      ar  = r && (sz > 0);
      ed  = '0;
      if (ar) ed = solo ? sq[0] : cq[0];
      if (solo) begin s_wr = w; s_wd = d; s_rd = r; end
      else      begin c_wr = w; c_wd = d; c_rd = r; end
      @(posedge clk);
      if (ar) begin
         if (solo) void'(sq.pop_front()); else void'(cq.pop_front());
      end
      if (aw) begin
         if (solo) sq.push_back(d); else cq.push_back(d);
      end
      @(negedge clk);
      s_wr = 1'b0; s_rd = 1'b0; c_wr = 1'b0; c_rd = 1'b0;
      sz = solo ? sq.size() : cq.size();
      if (solo) begin
         chk(s_valid == ar, tag, "rd_valid", int'(s_valid), int'(ar));
         if (ar) chk(s_rdata == ed, tag, "rd_data", int'(s_rdata), int'(ed));
         chk(s_empty_n == (sz != 0), tag, "empty_n", int'(s_empty_n), int'(sz != 0));
         chk(s_full_n == (sz != cap), tag, "full_n", int'(s_full_n), int'(sz != cap));
      end else begin
         chk(c_valid == ar, tag, "rd_valid", int'(c_valid), int'(ar));
         if (ar) chk(c_rdata == ed, tag, "rd_data", int'(c_rdata), int'(ed));
         chk(c_empty_n == (sz != 0), tag, "empty_n", int'(c_empty_n), int'(sz != 0));
         chk(c_full_n == (sz != cap), tag, "full_n", int'(c_full_n), int'(sz != cap));
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(c_empty_n == 1'b0, "R1", "empty_n in reset", int'(c_empty_n), 0);
      chk(c_full_n == 1'b1, "R1", "full_n in reset", int'(c_full_n), 1);
      chk(c_valid == 1'b0, "R1", "rd_valid in reset", int'(c_valid), 0);
      chk(s_empty_n == 1'b0, "R1", "solo empty_n in reset", int'(s_empty_n), 0);
      rst_n = 1'b1;
      cq.delete();
      sq.delete();
      chk(c_empty_n == 1'b0 && c_full_n == 1'b1, "R1", "flags after release",
          int'({c_empty_n, c_full_n}), 1);
   endtask

   task automatic t_fill_drain();
      for (int i = 0; i < CAP; i++) step(1'b0, 1'b1, 1'b0, "R3/R7");
      step(1'b0, 1'b1, 1'b0, "R4");
      step(1'b0, 1'b1, 1'b0, "R4");
      for (int i = 0; i < CAP; i++) step(1'b0, 1'b0, 1'b1, "R2/R4/R8");
      step(1'b0, 1'b0, 1'b1, "R5");
      step(1'b0, 1'b1, 1'b0, "R5");
      step(1'b0, 1'b0, 1'b1, "R5/R6");
   endtask

   task automatic t_partial();
      for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b1, 1'b0, "R9");
      for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b0, 1'b1, "R6/R9");
      step(1'b0, 1'b0, 1'b0, "R6/R9");
      for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b1, "R9");
   endtask

   task automatic t_simul();
      for (int i = 0; i < CAP / 2; i++) step(1'b0, 1'b1, 1'b0, "R11");
      for (int i = 0; i < 3 * CAP; i++) step(1'b0, 1'b1, 1'b1, "R11");
      while (cq.size() > 0) step(1'b0, 1'b0, 1'b1, "R11/R2");
   endtask

   task automatic t_laps();
      for (int k = 0; k < 12 * CAP; k++)
         step(1'b0, (k % 3) != 2, (k % 5) < 3, "R8/R2");
      while (cq.size() > 0) step(1'b0, 1'b0, 1'b1, "R8");
   endtask

   task automatic t_reset_mid();
      for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 1'b1, 1'b0, "R1");
      t_reset();
      step(1'b0, 1'b1, 1'b0, "R1");
      step(1'b0, 1'b1, 1'b0, "R1");
      step(1'b0, 1'b0, 1'b1, "R1");
      step(1'b0, 1'b0, 1'b1, "R1");
   endtask

   task automatic t_solo();
      for (int i = 0; i < SDEPTH; i++) step(1'b1, 1'b1, 1'b0, "R10");
      step(1'b1, 1'b1, 1'b0, "R10/R4");
      for (int i = 0; i < SDEPTH; i++) step(1'b1, 1'b0, 1'b1, "R10");
      step(1'b1, 1'b0, 1'b1, "R10/R5");
      for (int k = 0; k < 6 * SDEPTH; k++)
         step(1'b1, (k % 2) == 0 || (k % 7) == 3, (k % 3) != 0, "R10");
      while (sq.size() > 0) step(1'b1, 1'b0, 1'b1, "R10");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_fill_drain();
      t_partial();
      t_simul();
      t_laps();
      t_reset_mid();
      t_solo();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule